// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Controller

This block is the clocked switching controller for a single synchronous buck phase. It takes one PWM command and produces two gate enables, one for the high-side switch and one for the low-side switch. The dead time between the two is not a fixed count: it depends on three digitized sense flags. Before the high side may turn on, the low-side gate must be seen discharged. Before the low side may turn on, the switch node must be seen low. When the switch node never falls, for example while the phase sinks current, a longer fallback timer turns the low side on anyway so that the bootstrap capacitor recharges in every cycle. The fallback timer starts once the high-side gate-source voltage is seen discharged.

The PWM input can also float at a mid level. This, and an active-low disable, parks both switches off. An active-low skip-mode input keeps the low side off for light-load operation, and the high side then still follows PWM. All sense flags arrive as synchronous single-bit inputs. Reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `gate_deadtime_ctrl`

## Requirements
- R1: The outputs hs_en_o and ls_en_o are never high in the same cycle.
- R2: While rst_n is low, hs_en_o and ls_en_o are 0 and state_o is 0. The state_o encoding is: 0 both off, 1 waiting for the low side to discharge, 2 high side on, 3 waiting for the switch node, 4 low side on.
- R3: PWM is sampled high (the block enabled, not floating) and ls_gate_low_i is high continuously. ls_en_o is 0 one cycle later and hs_en_o rises exactly ADAPT_LH+1 cycles after the first such sample. hs_en_o stays 0 while ls_gate_low_i is 0. After the flag rises, hs_en_o follows ADAPT_LH cycles later.
- R4: PWM is sampled low with skip_n_i high, and sw_node_low_i is high continuously. hs_en_o is 0 one cycle later and ls_en_o rises exactly ADAPT_HL+1 cycles after the first such sample. The switch-node flag must stay high for ADAPT_HL consecutive cycles. A shorter pulse does not turn the low side on.
- R5: In state 3, the first cycle that samples hs_vgs_low_i high starts a fallback timer. ls_en_o then rises FALLBACK cycles later, whatever sw_node_low_i and later hs_vgs_low_i do. If neither flag ever rises, the low side stays off and state_o stays 3.
- R6: A cycle that samples disable_n_i at 0 makes hs_en_o and ls_en_o 0 and state_o 0 in the next cycle, and this holds whatever PWM does.
- R7: A cycle that samples pwm_mid_i at 1 makes hs_en_o and ls_en_o 0 and state_o 0 in the next cycle.
- R8: While skip_n_i is sampled 0, ls_en_o is 0 in the following cycle, and PWM low leads to state 0. The high side keeps the R3 timing.
- R9: PWM reverses while in state 1 or state 3. The next cycle shows the opposite waiting state (3 or 1), and the turn-on then follows the full R3 or R4 timing.
- R10: After disable_n_i returns to 1, the first turn-on follows the same R3 or R4 timing as any other turn-on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_i | input | 1 | PWM command level |
| pwm_mid_i | input | 1 | PWM floating at mid level |
| disable_n_i | input | 1 | Active-low disable |
| skip_n_i | input | 1 | Active-low skip mode (low side held off) |
| ls_gate_low_i | input | 1 | Low-side gate voltage below threshold |
| sw_node_low_i | input | 1 | Switch node below threshold |
| hs_vgs_low_i | input | 1 | High-side gate-source voltage discharged |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |
| state_o | output | 3 | Phase state code |

## Verification
Both enables are decoded straight from the state register, so a wrong state shows on hs_en_o, ls_en_o and state_o in the cycle after the faulty transition. The shoot-through check sees an overlap at once. A dead-time count that is off by one moves the turn-on edge by one cycle, and the bench samples the cycle before and the cycle of the expected edge to catch it. A fallback timer that restarts, never arms, or fires early shows up as a low-side edge away from cycle FALLBACK, or as a low side that should have stayed off coming on.

// File: rtl/gdt_pkg.sv
package gdt_pkg;

  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_LS_WAIT = 3'd1,
    ST_HS_ON   = 3'd2,
    ST_HS_WAIT = 3'd3,
    ST_LS_ON   = 3'd4
  } phase_t;

endpackage

// File: rtl/gdt_cmd_decode.sv
module gdt_cmd_decode (
  input  logic pwm_i,
  input  logic pwm_mid_i,
  input  logic disable_n_i,
  input  logic skip_n_i,
  output logic force_off_o,
  output logic want_hs_o,
  output logic want_ls_o
);

  always_comb begin
    force_off_o = !disable_n_i || pwm_mid_i;
    want_hs_o   = !force_off_o && pwm_i;
    want_ls_o   = !force_off_o && !pwm_i && skip_n_i;
  end

endmodule

// File: rtl/gdt_dwell_timer.sv
module gdt_dwell_timer #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  output logic done_o,
  output logic busy_o
);

  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    done_o = run_i && !clr_i && (cnt_q == CW'(LIMIT - 1));
    busy_o = (cnt_q != '0);
    cnt_en = 1'b1;
    if (clr_i || !run_i) begin
      cnt_d = '0;
    end else if (done_o) begin
      cnt_d  = cnt_q;
      cnt_en = 1'b0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/gdt_phase_fsm.sv
module gdt_phase_fsm
  import gdt_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   force_off_i,
  input  logic   want_hs_i,
  input  logic   want_ls_i,
  input  logic   lh_done_i,
  input  logic   hl_done_i,
  input  logic   fb_done_i,
  output phase_t state_o
);

  phase_t state_q;
  phase_t state_d;

  always_comb begin
    state_d = state_q;
    if (force_off_i) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          if (want_hs_i)      state_d = ST_LS_WAIT;
          else if (want_ls_i) state_d = ST_HS_WAIT;
        end
        ST_LS_WAIT: begin
          if (want_hs_i)      state_d = lh_done_i ? ST_HS_ON : ST_LS_WAIT;
          else if (want_ls_i) state_d = ST_HS_WAIT;
          else                state_d = ST_OFF;
        end
        ST_HS_ON: begin
          if (want_ls_i)       state_d = ST_HS_WAIT;
          else if (!want_hs_i) state_d = ST_OFF;
        end
        ST_HS_WAIT: begin
          if (want_ls_i)      state_d = (hl_done_i || fb_done_i) ? ST_LS_ON : ST_HS_WAIT;
          else if (want_hs_i) state_d = ST_LS_WAIT;
          else                state_d = ST_OFF;
        end
        ST_LS_ON: begin
          if (want_hs_i)       state_d = ST_LS_WAIT;
          else if (!want_ls_i) state_d = ST_OFF;
        end
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;

  // R9: reversal in a wait state moves to the opposite wait state
  assert_abort_ls_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LS_WAIT && want_ls_i && !force_off_i) |=> (state_q == ST_HS_WAIT));
  assert_abort_hs_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HS_WAIT && want_hs_i && !force_off_i) |=> (state_q == ST_LS_WAIT));

endmodule

// File: rtl/gate_deadtime_ctrl.sv
module gate_deadtime_ctrl
  import gdt_pkg::*;
#(
  parameter int ADAPT_LH = 3,
  parameter int ADAPT_HL = 4,
  parameter int FALLBACK = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwm_i,
  input  logic       pwm_mid_i,
  input  logic       disable_n_i,
  input  logic       skip_n_i,
  input  logic       ls_gate_low_i,
  input  logic       sw_node_low_i,
  input  logic       hs_vgs_low_i,
  output logic       hs_en_o,
  output logic       ls_en_o,
  output logic [2:0] state_o
);

  logic   rst_meta_q;
  logic   rst_sync_n;
  logic   force_off;
  logic   want_hs;
  logic   want_ls;
  logic   lh_done;
  logic   hl_done;
  logic   fb_done;
  logic   lh_busy;
  logic   hl_busy;
  logic   fb_busy;
  logic   fb_run;
  phase_t state;

  // Reset: asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  gdt_cmd_decode u_decode (
    .pwm_i       (pwm_i),
    .pwm_mid_i   (pwm_mid_i),
    .disable_n_i (disable_n_i),
    .skip_n_i    (skip_n_i),
    .force_off_o (force_off),
    .want_hs_o   (want_hs),
    .want_ls_o   (want_ls)
  );

  // Low-side discharge qualifier before high-side turn-on
  gdt_dwell_timer #(.LIMIT(ADAPT_LH)) u_lh_timer (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr_i  (state != ST_LS_WAIT),
    .run_i  (ls_gate_low_i),
    .done_o (lh_done),
    .busy_o (lh_busy)
  );

  // Switch-node qualifier before low-side turn-on
  gdt_dwell_timer #(.LIMIT(ADAPT_HL)) u_hl_timer (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr_i  (state != ST_HS_WAIT),
    .run_i  (sw_node_low_i),
    .done_o (hl_done),
    .busy_o (hl_busy)
  );

  // Fallback: armed by high-side discharge, keeps running once started
  assign fb_run = hs_vgs_low_i || fb_busy;

  gdt_dwell_timer #(.LIMIT(FALLBACK)) u_fb_timer (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr_i  (state != ST_HS_WAIT),
    .run_i  (fb_run),
    .done_o (fb_done),
    .busy_o (fb_busy)
  );

  gdt_phase_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .force_off_i (force_off),
    .want_hs_i   (want_hs),
    .want_ls_i   (want_ls),
    .lh_done_i   (lh_done),
    .hl_done_i   (hl_done),
    .fb_done_i   (fb_done),
    .state_o     (state)
  );

  assign hs_en_o = (state == ST_HS_ON);
  assign ls_en_o = (state == ST_LS_ON);
  assign state_o = state;

  // Timer busy flags for the adaptive windows feed only observation
  assert_lh_idle_outside_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state != ST_LS_WAIT) |=> !lh_busy);
  assert_hl_idle_outside_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state != ST_HS_WAIT) |=> !hl_busy);

  assert_no_overlap_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(hs_en_o && ls_en_o));

  assert_hs_after_discharge_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(hs_en_o) |-> ($past(ls_gate_low_i) && $past(state_o) == 3'd1));

  assert_ls_after_wait_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(ls_en_o) |-> ($past(state_o) == 3'd3));

  assert_fallback_fires_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state == ST_HS_WAIT && want_ls && fb_done) |=> ls_en_o);

  assert_disable_off_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !disable_n_i |=> (!hs_en_o && !ls_en_o && state_o == 3'd0));

  assert_mid_off_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pwm_mid_i |=> (!hs_en_o && !ls_en_o && state_o == 3'd0));

  assert_skip_ls_off_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !skip_n_i |=> !ls_en_o);

endmodule

// File: tb/tb_gate_deadtime_ctrl.sv
`timescale 1ns/1ps
module tb_gate_deadtime_ctrl;

  localparam int LH = 3;
  localparam int HL = 4;
  localparam int FB = 50;

  logic clk;
  logic rst_n;
  logic pwm, mid, dis_n, skip_n, lgl, swl, vgs;
  logic hs, ls;
  logic [2:0] st;

  int n_chk;
  int n_fail;
  bit finished;

  gate_deadtime_ctrl #(.ADAPT_LH(LH), .ADAPT_HL(HL), .FALLBACK(FB)) dut (
    .clk(clk), .rst_n(rst_n), .pwm_i(pwm), .pwm_mid_i(mid),
    .disable_n_i(dis_n), .skip_n_i(skip_n), .ls_gate_low_i(lgl),
    .sw_node_low_i(swl), .hs_vgs_low_i(vgs),
    .hs_en_o(hs), .ls_en_o(ls), .state_o(st)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int hs_turn_on_delay();
    return LH + 1;
  endfunction

  function automatic int ls_turn_on_delay();
    return HL + 1;
  endfunction

  function automatic int fallback_delay();
    return FB + 1;
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  // Expect a rising edge of sig exactly d cycles after the current negedge
  task automatic expect_hs_edge(input string tag, input int d);
    repeat (d - 1) step();
    chk({tag, " hs before edge"}, int'(hs), 0);
    step();
    chk({tag, " hs at edge"}, int'(hs), 1);
  endtask

  task automatic expect_ls_edge(input string tag, input int d);
    repeat (d - 1) step();
    chk({tag, " ls before edge"}, int'(ls), 0);
    step();
    chk({tag, " ls at edge"}, int'(ls), 1);
  endtask

  task automatic park_off();
    dis_n = 1'b0;
    step();
    step();
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    logic p_pwm, p_mid, p_dis, p_skip;
    n_chk = 0; n_fail = 0; finished = 1'b0;
    rst_n = 1'b0; pwm = 1'b0; mid = 1'b0; dis_n = 1'b0; skip_n = 1'b1;
    lgl = 1'b0; swl = 1'b0; vgs = 1'b0;
    repeat (3) step();
    chk("R2 reset hs", int'(hs), 0);
    chk("R2 reset ls", int'(ls), 0);
    chk("R2 reset state", int'(st), 0);
    rst_n = 1'b1;
    repeat (4) step();

    // R4: low-side turn-on from off, switch node already low
    dis_n = 1'b1; pwm = 1'b0; swl = 1'b1;
    step();
    chk("R4 wait state", int'(st), 3);
    expect_ls_edge("R4 from off", ls_turn_on_delay() - 1);

    // R3: high-side turn-on from low side on
    pwm = 1'b1; lgl = 1'b1; swl = 1'b0;
    step();
    chk("R3 ls drops", int'(ls), 0);
    chk("R3 wait state", int'(st), 1);
    expect_hs_edge("R3 from ls", hs_turn_on_delay() - 1);

    // R4: from high side on; hs drops after one cycle
    pwm = 1'b0; swl = 1'b1; lgl = 1'b0;
    step();
    chk("R4 hs drops", int'(hs), 0);
    expect_ls_edge("R4 from hs", ls_turn_on_delay() - 1);

    // R3: discharge flag held off, high side waits
    pwm = 1'b1; swl = 1'b0;
    repeat (20) step();
    chk("R3 hs held off", int'(hs), 0);
    chk("R3 still waiting", int'(st), 1);
    lgl = 1'b1;
    expect_hs_edge("R3 late flag", LH);

    // R5: fallback with switch node stuck high (flag low)
    pwm = 1'b0; lgl = 1'b0; swl = 1'b0; vgs = 1'b1;
    expect_ls_edge("R5 fallback", fallback_delay());

    // R5: late one-cycle discharge pulse still arms the timer
    vgs = 1'b0; pwm = 1'b1; lgl = 1'b1;
    repeat (hs_turn_on_delay()) step();
    chk("R3 back to hs", int'(hs), 1);
    pwm = 1'b0; lgl = 1'b0;
    repeat (10) step();
    chk("R5 waiting no flags", int'(st), 3);
    vgs = 1'b1;
    step();
    vgs = 1'b0;
    repeat (FB - 2) step();
    chk("R5 pulse before edge", int'(ls), 0);
    step();
    chk("R5 pulse at edge", int'(ls), 1);

    // R5: no flag at all keeps low side off
    pwm = 1'b1; lgl = 1'b1;
    repeat (hs_turn_on_delay()) step();
    pwm = 1'b0; lgl = 1'b0;
    repeat (100) step();
    chk("R5 no flag ls", int'(ls), 0);
    chk("R5 no flag state", int'(st), 3);

    // R4: short switch-node pulse is not enough
    swl = 1'b1;
    step(); step();
    swl = 1'b0;
    repeat (5) step();
    chk("R4 short pulse ls", int'(ls), 0);
    swl = 1'b1;
    expect_ls_edge("R4 after pulse", HL);

    // R9: reversal during low-side discharge wait
    pwm = 1'b1; lgl = 1'b0;
    step();
    chk("R9 into ls wait", int'(st), 1);
    pwm = 1'b0;
    step();
    chk("R9 abort to hs wait", int'(st), 3);
    expect_ls_edge("R9 ls after abort", HL);

    // R9: reversal during switch-node wait
    pwm = 1'b1; lgl = 1'b1;
    repeat (hs_turn_on_delay()) step();
    pwm = 1'b0; lgl = 1'b0; swl = 1'b0; vgs = 1'b0;
    step();
    chk("R9 into hs wait", int'(st), 3);
    pwm = 1'b1; lgl = 1'b1;
    step();
    chk("R9 abort to ls wait", int'(st), 1);
    expect_hs_edge("R9 hs after abort", LH);

    // R6: disable forces both off, regardless of PWM
    dis_n = 1'b0;
    step();
    chk("R6 hs off", int'(hs), 0);
    chk("R6 state off", int'(st), 0);
    swl = 1'b1;
    for (int i = 0; i < 12; i++) begin
      pwm = i[1];
      step();
      chk("R6 hold off", int'(hs) + int'(ls), 0);
    end

    // R10: re-enable follows full threshold timing
    dis_n = 1'b1; pwm = 1'b1; lgl = 1'b1;
    step();
    chk("R10 wait after enable", int'(st), 1);
    expect_hs_edge("R10 hs", LH);

    // R7: mid-level PWM forces both off
    mid = 1'b1;
    step();
    chk("R7 both off", int'(hs) + int'(ls), 0);
    chk("R7 state off", int'(st), 0);
    pwm = 1'b0; swl = 1'b1;
    repeat (10) step();
    chk("R7 ls held off", int'(ls), 0);
    mid = 1'b0;
    expect_ls_edge("R7 release", ls_turn_on_delay());

    // R8: skip mode keeps low side off, high side works
    skip_n = 1'b0;
    step();
    chk("R8 ls off", int'(ls), 0);
    chk("R8 state off", int'(st), 0);
    repeat (20) step();
    chk("R8 ls stays off", int'(ls), 0);
    pwm = 1'b1; lgl = 1'b1;
    expect_hs_edge("R8 hs", hs_turn_on_delay());
    pwm = 1'b0;
    step();
    chk("R8 hs drop", int'(hs), 0);
    chk("R8 idle state", int'(st), 0);
    repeat (20) step();
    chk("R8 no ls", int'(ls), 0);
    skip_n = 1'b1;
    park_off();

    // Random mix with cycle-level invariant checks
    void'($urandom(32'd20240611));
    dis_n = 1'b1;
    p_pwm = pwm; p_mid = mid; p_dis = dis_n; p_skip = skip_n;
    for (int c = 0; c < 4000; c++) begin
      if ($urandom % 12 == 0) pwm = ~pwm;
      mid   = ($urandom % 40 == 0);
      dis_n = ($urandom % 50 != 0);
      if ($urandom % 200 == 0) skip_n = ~skip_n;
      lgl = ($urandom % 3 != 0);
      swl = ($urandom % 4 == 0);
      vgs = ($urandom % 6 == 0);
      p_pwm = pwm; p_mid = mid; p_dis = dis_n; p_skip = skip_n;
      step();
      chk("R1 random overlap", int'(hs && ls), 0);
      if (!p_dis) chk("R6 random disable", int'(hs) + int'(ls), 0);
      if (p_mid)  chk("R7 random mid", int'(hs) + int'(ls), 0);
      if (!p_skip) chk("R8 random skip", int'(ls), 0);
      if (hs) chk("R3 random hs cause", int'(p_pwm && !p_mid && p_dis), 1);
    end

    summary();
  end

endmodule